// File: doc/BRIEF.md
# Rounded Math Constant Loader

This block produces one of seven fixed floating-point constants in 80-bit extended-precision form (sign, 15-bit biased exponent, 64-bit significand with explicit integer bit), ready to be written into the top entry of a floating-point register stack. A start strobe presents an opcode byte and the current 2-bit rounding-control field. One clock later the block returns the value, a done strobe and a push request. The stack itself lives outside the block. The caller reports whether the entry that would become the new top is already occupied.

Each non-trivial constant is stored with a 66-bit significand, which is two bits beyond the result width. It is rounded to 64 bits in the mode in force when the strobe arrives. The rounding never raises an inexact indication. The only condition flag the block drives reflects stack overflow. If the rounding carries out of the significand, the block renormalises by incrementing the exponent.

Top module: `cload_top`

## Requirements
- R1: Opcode byte 8'hE8 gives +1.0, E9 gives log2(10), EA gives log2(e), EB gives pi, EC gives log10(2), ED gives ln(2) and EE gives +0.0. Every result has sign bit 79 clear, exponent in bits 78:64 and significand in bits 63:0.
- R2: With rounding control 2'b00 (nearest-even), the results equal the legacy values {exponent, significand}. These are 3FFF/8000000000000000, 4000/D49A784BCD1B8AFE, 3FFF/B8AA3B295C17F0BC, 4000/C90FDAA22168C235, 3FFD/9A209A84FBCFF799, 3FFE/B17217F7D1CF79AC, and all zero for +0.0.
- R3: With rounding control 2'b10 (toward plus infinity), log2(10) becomes ...8AFF. The other constants keep their R2 values.
- R4: With rounding control 2'b01 (toward minus infinity) or 2'b11 (toward zero), log2(10) keeps ...8AFE. The significands of log2(e), pi, log10(2) and ln(2) are one less than in R2.
- R5: +1.0 and +0.0 are identical under all four rounding modes.
- R6: done_o is high in exactly the cycle after a cycle with start_i high.
- R7: For a valid opcode with dest_full_i low, push_o pulses together with done_o, and c1_o and stack_fault_o read 0.
- R8: For a valid opcode with dest_full_i high, c1_o and stack_fault_o read 1 and push_o stays low.
- R9: An opcode outside E8..EE completes with done_o high, push_o low, no fault, and result_o all zero.
- R10: Without start_i, result_o, c1_o and stack_fault_o hold their values and done_o and push_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Constant-select opcode byte |
| rc_i | input | 2 | Rounding control |
| dest_full_i | input | 1 | The new top stack entry is already occupied |
| result_o | output | 80 | Rounded extended-precision constant |
| done_o | output | 1 | Request completed |
| push_o | output | 1 | Write result_o into the stack and move the top pointer |
| c1_o | output | 1 | Overflow condition flag |
| stack_fault_o | output | 1 | Stack overflow fault |

## Verification
The assertions check the following on every cycle:
- the one-cycle latency of done_o;
- that a push never coincides with an overflow;
- that overflow on a valid opcode always faults;
- that invalid opcodes never push;
- that results are positive;
- that results hold between requests.

Only the bench scenarios can show that each opcode and rounding mode yields the exact expected bit pattern. This covers the nearest-even tie on log2(e), the single constant that moves under round-up, and the four that drop by one unit under round-down and truncation.

// File: rtl/cload_pkg.sv
package cload_pkg;
    localparam int SIG_W  = 64;
    localparam int GRD_W  = 2;
    localparam int EXP_W  = 15;
    localparam int OPC_W  = 8;
    localparam int RC_W   = 2;
    localparam int NCONST = 7;
    localparam int WIDE_W = SIG_W + GRD_W;
    localparam int FP_W   = 1 + EXP_W + SIG_W;
    localparam logic [OPC_W-1:0] BASE_OPC = 8'hE8;

    typedef enum logic [RC_W-1:0] {
        RC_NEAR = 2'b00,
        RC_DOWN = 2'b01,
        RC_UP   = 2'b10,
        RC_ZERO = 2'b11
    } rc_e;

    typedef struct packed {
        logic [FP_W-1:0] result;
        logic            done;
        logic            push;
        logic            c1;
        logic            fault;
    } out_s;
endpackage

// File: rtl/cload_rom.sv
module cload_rom
    import cload_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode_i,
    output logic              valid_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [WIDE_W-1:0] wide_o
);
    logic [OPC_W-1:0] offs;

    always_comb begin
        offs    = opcode_i - BASE_OPC;
        valid_o = (opcode_i >= BASE_OPC) && (offs < OPC_W'(NCONST));
        exp_o   = '0;
        wide_o  = '0;
        if (valid_o) begin
            case (offs[2:0])
                3'd0: begin exp_o = 15'h3FFF; wide_o = {64'h8000000000000000, 2'b00}; end
                3'd1: begin exp_o = 15'h4000; wide_o = {64'hD49A784BCD1B8AFE, 2'b01}; end
                3'd2: begin exp_o = 15'h3FFF; wide_o = {64'hB8AA3B295C17F0BB, 2'b10}; end
                3'd3: begin exp_o = 15'h4000; wide_o = {64'hC90FDAA22168C234, 2'b11}; end
                3'd4: begin exp_o = 15'h3FFD; wide_o = {64'h9A209A84FBCFF798, 2'b11}; end
                3'd5: begin exp_o = 15'h3FFE; wide_o = {64'hB17217F7D1CF79AB, 2'b11}; end
                default: begin exp_o = '0; wide_o = '0; end
            endcase
        end
    end
endmodule

// File: rtl/cload_round.sv
module cload_round
    import cload_pkg::*;
(
    input  logic [WIDE_W-1:0] wide_i,
    input  logic [RC_W-1:0]   rc_i,
    output logic [SIG_W-1:0]  sig_o,
    output logic              carry_o
);
    logic lsb, guard, sticky, inc;

    always_comb begin
        lsb    = wide_i[GRD_W];
        guard  = wide_i[GRD_W-1];
        sticky = |wide_i[GRD_W-2:0];
        case (rc_e'(rc_i))
            RC_NEAR: inc = guard & (sticky | lsb);
            RC_UP:   inc = guard | sticky;
            default: inc = 1'b0;
        endcase
        {carry_o, sig_o} = {1'b0, wide_i[WIDE_W-1:GRD_W]} + (SIG_W+1)'(inc);
    end
endmodule

// File: rtl/cload_top.sv
module cload_top
    import cload_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [1:0]        rc_i,
    input  logic              dest_full_i,
    output logic [79:0]       result_o,
    output logic              done_o,
    output logic              push_o,
    output logic              c1_o,
    output logic              stack_fault_o
);
    logic              rom_valid;
    logic [EXP_W-1:0]  rom_exp;
    logic [WIDE_W-1:0] rom_wide;
    logic [SIG_W-1:0]  rnd_sig;
    logic              rnd_carry;
    logic [EXP_W-1:0]  fin_exp;
    logic [SIG_W-1:0]  fin_sig;
    out_s              st_d, st_q;

    cload_rom rom_i (
        .opcode_i (opcode_i),
        .valid_o  (rom_valid),
        .exp_o    (rom_exp),
        .wide_o   (rom_wide)
    );

    cload_round rnd_i (
        .wide_i  (rom_wide),
        .rc_i    (rc_i),
        .sig_o   (rnd_sig),
        .carry_o (rnd_carry)
    );

    always_comb begin
        fin_exp = rnd_carry ? rom_exp + EXP_W'(1) : rom_exp;
        fin_sig = rnd_carry ? {1'b1, {(SIG_W-1){1'b0}}} : rnd_sig;

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.push = 1'b0;
        if (start_i) begin
            st_d.done = 1'b1;
            if (rom_valid) begin
                st_d.result = {1'b0, fin_exp, fin_sig};
                st_d.push   = !dest_full_i;
                st_d.c1     = dest_full_i;
                st_d.fault  = dest_full_i;
            end else begin
                st_d.result = '0;
                st_d.c1     = 1'b0;
                st_d.fault  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o      = st_q.result;
    assign done_o        = st_q.done;
    assign push_o        = st_q.push;
    assign c1_o          = st_q.c1;
    assign stack_fault_o = st_q.fault;
endmodule

// File: rtl/cload_chk.sv
module cload_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [7:0]  opcode_i,
    input logic        dest_full_i,
    input logic [79:0] result_o,
    input logic        done_o,
    input logic        push_o,
    input logic        c1_o,
    input logic        stack_fault_o
);
    logic op_ok;
    assign op_ok = (opcode_i >= 8'hE8) && (opcode_i <= 8'hEE);

    assert_done_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    assert_done_only_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o && !push_o);
    assert_push_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> done_o && !c1_o && !stack_fault_o);
    assert_overflow_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && op_ok && dest_full_i |=> stack_fault_o && c1_o && !push_o);
    assert_bad_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !op_ok |=> !push_o && !stack_fault_o && (result_o == 80'd0));
    assert_positive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !result_o[79]);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o) && $stable(c1_o) && $stable(stack_fault_o));
endmodule

bind cload_top cload_chk chk_i (.*);

// File: tb/cload_tb.sv
module cload_top_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [1:0]  rc_i = 2'b00;
    logic        dest_full_i = 1'b0;
    logic [79:0] result_o;
    logic        done_o, push_o, c1_o, stack_fault_o;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cload_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .rc_i(rc_i), .dest_full_i(dest_full_i), .result_o(result_o),
        .done_o(done_o), .push_o(push_o), .c1_o(c1_o), .stack_fault_o(stack_fault_o)
    );

    function automatic logic [79:0] legacy(input logic [7:0] opc);
        case (opc)
            8'hE8: legacy = {1'b0, 15'h3FFF, 64'h8000000000000000};
            8'hE9: legacy = {1'b0, 15'h4000, 64'hD49A784BCD1B8AFE};
            8'hEA: legacy = {1'b0, 15'h3FFF, 64'hB8AA3B295C17F0BC};
            8'hEB: legacy = {1'b0, 15'h4000, 64'hC90FDAA22168C235};
            8'hEC: legacy = {1'b0, 15'h3FFD, 64'h9A209A84FBCFF799};
            8'hED: legacy = {1'b0, 15'h3FFE, 64'hB17217F7D1CF79AC};
            default: legacy = 80'd0;
        endcase
    endfunction

    function automatic logic [79:0] expect_val(input logic [7:0] opc, input logic [1:0] rc);
        logic [79:0] v;
        v = legacy(opc);
        if (rc == 2'b10 && opc == 8'hE9) v = v + 80'd1;
        if ((rc == 2'b01 || rc == 2'b11) && opc >= 8'hEA && opc <= 8'hED) v = v - 80'd1;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] opc, input logic [1:0] rc, input logic full);
        @(negedge clk);
        start_i = 1'b1; opcode_i = opc; rc_i = rc; dest_full_i = full;
        @(negedge clk);
        start_i = 1'b0; dest_full_i = 1'b0;
    endtask

    task automatic t_reset();
        check(result_o == 80'd0 && !done_o && !push_o && !c1_o && !stack_fault_o,
              "R10", "reset state", {75'd0, done_o, push_o, c1_o, stack_fault_o, 1'b0}, 80'd0);
    endtask

    task automatic t_mode(input logic [1:0] rc, input string req);
        for (int k = 0; k < 7; k++) begin
            logic [7:0] opc;
            opc = 8'hE8 + 8'(k);
            issue(opc, rc, 1'b0);
            check(result_o == expect_val(opc, rc), req, $sformatf("value op=%h rc=%0d", opc, rc),
                  result_o, expect_val(opc, rc));
            check(done_o && push_o && !c1_o && !stack_fault_o, "R7", "push without fault",
                  {76'd0, done_o, push_o, c1_o, stack_fault_o}, 80'hC);
            check(!result_o[79], "R1", "sign clear", {79'd0, result_o[79]}, 80'd0);
        end
    endtask

    task automatic t_exact();
        for (int m = 0; m < 4; m++) begin
            issue(8'hE8, 2'(m), 1'b0);
            check(result_o == {1'b0, 15'h3FFF, 64'h8000000000000000}, "R5", "one exact",
                  result_o, {1'b0, 15'h3FFF, 64'h8000000000000000});
            issue(8'hEE, 2'(m), 1'b0);
            check(result_o == 80'd0, "R5", "zero exact", result_o, 80'd0);
        end
    endtask

    task automatic t_latency();
        @(negedge clk);
        start_i = 1'b1; opcode_i = 8'hEB; rc_i = 2'b00;
        @(posedge clk); #1;
        start_i = 1'b0;
        check(done_o, "R6", "done one cycle later", {79'd0, done_o}, 80'd1);
        @(posedge clk); #1;
        check(!done_o && !push_o, "R6", "done single pulse", {78'd0, done_o, push_o}, 80'd0);
    endtask

    task automatic t_overflow();
        issue(8'hEA, 2'b00, 1'b1);
        check(c1_o && stack_fault_o && !push_o && done_o, "R8", "overflow",
              {76'd0, done_o, push_o, c1_o, stack_fault_o}, 80'hB);
        issue(8'hED, 2'b10, 1'b0);
        check(!c1_o && !stack_fault_o && push_o, "R7", "overflow cleared",
              {76'd0, done_o, push_o, c1_o, stack_fault_o}, 80'hC);
    endtask

    task automatic t_bad_opcode();
        issue(8'hEF, 2'b00, 1'b0);
        check(done_o && !push_o && !stack_fault_o && result_o == 80'd0, "R9", "opcode EF",
              result_o, 80'd0);
        issue(8'hE7, 2'b10, 1'b1);
        check(done_o && !push_o && !stack_fault_o && !c1_o, "R9", "opcode E7 no fault",
              {76'd0, done_o, push_o, c1_o, stack_fault_o}, 80'h8);
    endtask

    task automatic t_idle_hold();
        logic [79:0] held;
        issue(8'hEC, 2'b00, 1'b1);
        held = result_o;
        @(negedge clk); opcode_i = 8'hE9; rc_i = 2'b10; dest_full_i = 1'b0;
        repeat (3) @(negedge clk);
        check(result_o == held && c1_o && stack_fault_o && !done_o && !push_o, "R10",
              "hold while idle", result_o, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_mode(2'b00, "R2");
        t_mode(2'b10, "R3");
        t_mode(2'b01, "R4");
        t_mode(2'b11, "R4");
        t_exact();
        t_latency();
        t_overflow();
        t_bad_opcode();
        t_idle_hold();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule